// File: doc/BRIEF.md
# Hard-wired TEA Encipher Task

This block is a self-contained hardware task that enciphers one 64-bit block with the Tiny Encryption Algorithm. Its program is fixed in a control state machine that steers a small datapath directly; nothing is fetched or decoded. The datapath holds a seven-entry register file for the task's locals (two text halves, four key words and the running sum), a three-entry constant ROM, and an ALU that adds, shifts and exclusive-ORs. All global data moves through one byte-wide port to a shared RAM.

A one-cycle start pulse wakes the task. It raises its supply-enable output and reads the two plaintext words and then the four key words from the shared RAM. It then performs 32 rounds and writes the two ciphertext words back. Finally it pulses done and drops the supply enable. The task keeps no state from one job to the next, so its domain may be switched off between jobs.

The shared-RAM port is a valid/ready request channel plus a valid/ready read-response channel. A request stays on the bus, unchanged, until the RAM accepts it with ready. Back-pressure on reads comes from the RAM delaying its response, and the task waits for that response as long as needed. Only one request is outstanding at any time.

Top module: `tea_task_core`

## Requirements
- R1: After reset, `pwr_en`, `task_done`, `mem_req_valid` and `mem_rsp_ready` are all 0.
- R2: A `task_start` pulse seen while `pwr_en` is 0 raises `pwr_en` on the next cycle. A `task_start` pulse seen while `pwr_en` is 1 has no effect: it causes no second job, no extra done pulse and no further RAM traffic.
- R3: The task reads exactly 24 bytes in this order: plaintext y, plaintext z, then keys a, b, c and d. Each word is read low byte first. y is at `PT_BASE+0..3`, z at `PT_BASE+4..7`, and key word k at `KEY_BASE+4k..4k+3`. Every read has `mem_req_write` = 0.
- R4: The ciphertext is 32 TEA rounds, with all arithmetic modulo 2^32. The sum starts at 0, and each round adds 0x9E3779B9 to it. Each round then sets y += ((z<<4)+a) ^ (z+sum) ^ ((z>>5)+b), and then sets z += ((y<<4)+c) ^ (y+sum) ^ ((y>>5)+d), using the new y.
- R5: The task writes exactly 8 bytes with `mem_req_write` = 1. It writes y and then z, each low byte first, to `CT_BASE+0..7`.
- R6: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the next cycle keeps `mem_req_valid` at 1 and holds address, write flag and write data unchanged.
- R7: `task_done` is 1 for exactly one cycle: the cycle after the last write is accepted. `pwr_en` is 0 on the cycle after `task_done`.
- R8: `mem_rsp_ready` is 1 only while a read response is awaited, and never in the same cycle as `mem_req_valid`. Exactly 24 responses are consumed per job.
- R9: Jobs run back to back without reset give results that depend only on each job's own RAM contents, with no dependence on earlier jobs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_start | input | 1 | Start pulse, honoured only while idle |
| pwr_en | output | 1 | Supply enable for the task domain, high from wake to done |
| task_done | output | 1 | One-cycle job-complete pulse |
| mem_req_valid | output | 1 | RAM request valid |
| mem_req_ready | input | 1 | RAM accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Task waiting for read data |
| mem_rsp_rdata | input | 8 | Read byte |

## Verification
Two events can meet in one cycle: a fresh `task_start` and the job's `task_done`. The supply is still on at that moment, so the start must be ignored rather than starting a second job. The bench raises `task_start` exactly in the done cycle, and also in the middle of the rounds. It then checks that only one done pulse occurs and that `pwr_en` falls and stays low. A second overlap occurs under RAM stalls, where a request waits on `ready` in the same cycle as the address advances. The bench runs with ready withheld two cycles in three and with delayed responses, and checks that each request stays stable while it waits and that the byte order is exact.

// File: rtl/tea_task_pkg.sv
package tea_task_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int WORD_BY = WORD_W / BYTE_W;

  // register-file slots; text and key slots double as load word index
  localparam int RF_N     = 7;
  localparam int RF_IDX_W = $clog2(RF_N);
  localparam logic [RF_IDX_W-1:0] RF_Y   = 3'd0;
  localparam logic [RF_IDX_W-1:0] RF_Z   = 3'd1;
  localparam logic [RF_IDX_W-1:0] RF_KA  = 3'd2;
  localparam logic [RF_IDX_W-1:0] RF_KB  = 3'd3;
  localparam logic [RF_IDX_W-1:0] RF_KC  = 3'd4;
  localparam logic [RF_IDX_W-1:0] RF_KD  = 3'd5;
  localparam logic [RF_IDX_W-1:0] RF_SUM = 3'd6;

  localparam int LD_WORDS = 6;
  localparam int ST_WORDS = 2;
  localparam int RD_PORTS = 5;

  typedef enum logic [1:0] {
    CR_DELTA  = 2'd0,
    CR_ZERO   = 2'd1,
    CR_ROUNDS = 2'd2
  } const_sel_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_MIX  = 2'd2
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_INIT, ST_LD_REQ, ST_LD_WAIT,
    ST_SUM, ST_UPD_Y, ST_UPD_Z, ST_WR_REQ, ST_DONE
  } task_state_e;

endpackage

// File: rtl/tea_regfile.sv
module tea_regfile
  import tea_task_pkg::*;
#(
  parameter int NRD = RD_PORTS
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [RF_IDX_W-1:0]           wr_idx,
  input  logic [WORD_BY-1:0]            wr_be,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic [NRD-1:0][RF_IDX_W-1:0]  rd_idx,
  output logic [NRD-1:0][WORD_W-1:0]    rd_data
);

  logic [WORD_W-1:0] slot_q [RF_N];

  // contents are undefined at job start: no reset on the storage
  for (genvar e = 0; e < RF_N; e++) begin : g_slot
    for (genvar b = 0; b < WORD_BY; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx == RF_IDX_W'(e)) && wr_be[b])
          slot_q[e][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      rd_data[p] = '0;
      for (int e = 0; e < RF_N; e++)
        if (rd_idx[p] == RF_IDX_W'(e)) rd_data[p] = slot_q[e];
    end
  end

endmodule

// File: rtl/tea_const_rom.sv
module tea_const_rom
  import tea_task_pkg::*;
#(
  parameter logic [WORD_W-1:0] DELTA  = 32'h9E37_79B9,
  parameter int                ROUNDS = 32
) (
  input  const_sel_e         sel,
  output logic [WORD_W-1:0]  value
);

  always_comb begin
    unique case (sel)
      CR_DELTA:  value = DELTA;
      CR_ZERO:   value = '0;
      CR_ROUNDS: value = WORD_W'(ROUNDS);
      default:   value = '0;
    endcase
  end

endmodule

// File: rtl/tea_alu.sv
module tea_alu
  import tea_task_pkg::*;
#(
  parameter int SHL = 4,
  parameter int SHR = 5
) (
  input  alu_op_e            op,
  input  logic [WORD_W-1:0]  opa,
  input  logic [WORD_W-1:0]  opb,
  input  logic [WORD_W-1:0]  key_lo,
  input  logic [WORD_W-1:0]  key_hi,
  input  logic [WORD_W-1:0]  sum,
  output logic [WORD_W-1:0]  res
);

  logic [WORD_W-1:0] mix;

  always_comb begin
    mix = ((opb << SHL) + key_lo) ^ (opb + sum) ^ ((opb >> SHR) + key_hi);
    unique case (op)
      ALU_PASS: res = opb;
      ALU_ADD:  res = opa + opb;
      ALU_MIX:  res = opa + mix;
      default:  res = opb;
    endcase
  end

endmodule

// File: rtl/tea_task_ctrl.sv
module tea_task_ctrl
  import tea_task_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] PT_BASE  = 8'h00,
  parameter logic [ADDR_W-1:0] KEY_BASE = 8'h10,
  parameter logic [ADDR_W-1:0] CT_BASE  = 8'h20,
  parameter int                ROUNDS   = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  output logic                              pwr_en_o,
  output logic                              done_o,
  output logic                              req_valid_o,
  input  logic                              req_ready_i,
  output logic                              req_write_o,
  output logic [ADDR_W-1:0]                 req_addr_o,
  output logic [BYTE_W-1:0]                 req_wdata_o,
  input  logic                              rsp_valid_i,
  output logic                              rsp_ready_o,
  output const_sel_e                        rom_sel_o,
  input  logic [WORD_W-1:0]                 rom_val_i,
  output logic [RD_PORTS-1:0][RF_IDX_W-1:0] rd_idx_o,
  input  logic [WORD_W-1:0]                 st_word_i,
  output logic                              wr_en_o,
  output logic [RF_IDX_W-1:0]               wr_idx_o,
  output logic [WORD_BY-1:0]                wr_be_o,
  output logic                              wr_from_mem_o,
  output alu_op_e                           alu_op_o,
  output logic                              opb_rom_o
);

  localparam int CNT_W = $clog2(ROUNDS + 1);
  localparam int BY_W  = $clog2(WORD_BY);

  task_state_e          state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [RF_IDX_W-1:0]  word_q;
  logic [BY_W-1:0]      byte_q;

  logic                 req_fire, rsp_fire, last_byte;
  logic                 is_text;
  logic [RF_IDX_W-1:0]  rel_word;

  assign req_fire  = req_valid_o && req_ready_i;
  assign rsp_fire  = rsp_valid_i && rsp_ready_o;
  assign last_byte = (byte_q == BY_W'(WORD_BY - 1));
  assign is_text   = (word_q < RF_IDX_W'(ST_WORDS));
  assign rel_word  = is_text ? word_q : word_q - RF_IDX_W'(ST_WORDS);

  assign pwr_en_o = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);

  // bus side
  always_comb begin
    req_valid_o = 1'b0;
    req_write_o = 1'b0;
    req_addr_o  = '0;
    req_wdata_o = '0;
    rsp_ready_o = 1'b0;
    unique case (state_q)
      ST_LD_REQ: begin
        req_valid_o = 1'b1;
        req_addr_o  = (is_text ? PT_BASE : KEY_BASE) + ADDR_W'({rel_word, byte_q});
      end
      ST_LD_WAIT: rsp_ready_o = 1'b1;
      ST_WR_REQ: begin
        req_valid_o = 1'b1;
        req_write_o = 1'b1;
        req_addr_o  = CT_BASE + ADDR_W'({word_q, byte_q});
        req_wdata_o = st_word_i[{byte_q, 3'b000} +: BYTE_W];
      end
      default: ;
    endcase
  end

  // datapath steering
  always_comb begin
    rom_sel_o     = CR_DELTA;
    rd_idx_o[0]   = RF_Y;
    rd_idx_o[1]   = RF_Z;
    rd_idx_o[2]   = RF_KA;
    rd_idx_o[3]   = RF_KB;
    rd_idx_o[4]   = RF_SUM;
    wr_en_o       = 1'b0;
    wr_idx_o      = RF_SUM;
    wr_be_o       = '1;
    wr_from_mem_o = 1'b0;
    alu_op_o      = ALU_PASS;
    opb_rom_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: rom_sel_o = CR_ROUNDS;
      ST_INIT: begin
        rom_sel_o = CR_ZERO;
        opb_rom_o = 1'b1;
        wr_en_o   = 1'b1;
      end
      ST_LD_WAIT: begin
        wr_en_o       = rsp_fire;
        wr_idx_o      = word_q;
        wr_be_o       = WORD_BY'(1) << byte_q;
        wr_from_mem_o = 1'b1;
      end
      ST_SUM: begin
        rd_idx_o[0] = RF_SUM;
        alu_op_o    = ALU_ADD;
        opb_rom_o   = 1'b1;
        wr_en_o     = 1'b1;
      end
      ST_UPD_Y: begin
        alu_op_o = ALU_MIX;
        wr_en_o  = 1'b1;
        wr_idx_o = RF_Y;
      end
      ST_UPD_Z: begin
        rd_idx_o[0] = RF_Z;
        rd_idx_o[1] = RF_Y;
        rd_idx_o[2] = RF_KC;
        rd_idx_o[3] = RF_KD;
        alu_op_o    = ALU_MIX;
        wr_en_o     = 1'b1;
        wr_idx_o    = RF_Z;
      end
      ST_WR_REQ: rd_idx_o[1] = word_q;
      default: ;
    endcase
  end

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      word_q  <= '0;
      byte_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_INIT;
          cnt_q   <= CNT_W'(rom_val_i);
          word_q  <= '0;
          byte_q  <= '0;
        end
        ST_INIT:   state_q <= ST_LD_REQ;
        ST_LD_REQ: if (req_fire) state_q <= ST_LD_WAIT;
        ST_LD_WAIT: if (rsp_fire) begin
          byte_q  <= byte_q + 1'b1;
          state_q <= ST_LD_REQ;
          if (last_byte) begin
            if (word_q == RF_IDX_W'(LD_WORDS - 1)) begin
              word_q  <= '0;
              state_q <= ST_SUM;
            end else begin
              word_q <= word_q + 1'b1;
            end
          end
        end
        ST_SUM:   state_q <= ST_UPD_Y;
        ST_UPD_Y: state_q <= ST_UPD_Z;
        ST_UPD_Z: begin
          cnt_q   <= cnt_q - 1'b1;
          state_q <= (cnt_q == CNT_W'(1)) ? ST_WR_REQ : ST_SUM;
        end
        ST_WR_REQ: if (req_fire) begin
          byte_q <= byte_q + 1'b1;
          if (last_byte) begin
            if (word_q == RF_IDX_W'(ST_WORDS - 1)) state_q <= ST_DONE;
            else word_q <= word_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tea_task_core.sv
module tea_task_core
  import tea_task_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] PT_BASE  = 8'h00,
  parameter logic [ADDR_W-1:0] KEY_BASE = 8'h10,
  parameter logic [ADDR_W-1:0] CT_BASE  = 8'h20,
  parameter int                ROUNDS   = 32,
  parameter logic [31:0]       DELTA    = 32'h9E37_79B9,
  parameter int                SHL      = 4,
  parameter int                SHR      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              task_start,
  output logic              pwr_en,
  output logic              task_done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [7:0]        mem_rsp_rdata
);

  const_sel_e                         rom_sel;
  logic [WORD_W-1:0]                  rom_val;
  logic [RD_PORTS-1:0][RF_IDX_W-1:0]  rd_idx;
  logic [RD_PORTS-1:0][WORD_W-1:0]    rd_data;
  logic                               wr_en, wr_from_mem, opb_rom;
  logic [RF_IDX_W-1:0]                wr_idx;
  logic [WORD_BY-1:0]                 wr_be;
  logic [WORD_W-1:0]                  wr_data, alu_res, alu_opb;
  alu_op_e                            alu_op;

  tea_task_ctrl #(
    .ADDR_W(ADDR_W), .PT_BASE(PT_BASE), .KEY_BASE(KEY_BASE),
    .CT_BASE(CT_BASE), .ROUNDS(ROUNDS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(task_start),
    .pwr_en_o(pwr_en), .done_o(task_done),
    .req_valid_o(mem_req_valid), .req_ready_i(mem_req_ready),
    .req_write_o(mem_req_write), .req_addr_o(mem_req_addr),
    .req_wdata_o(mem_req_wdata),
    .rsp_valid_i(mem_rsp_valid), .rsp_ready_o(mem_rsp_ready),
    .rom_sel_o(rom_sel), .rom_val_i(rom_val),
    .rd_idx_o(rd_idx), .st_word_i(rd_data[1]),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_be_o(wr_be),
    .wr_from_mem_o(wr_from_mem), .alu_op_o(alu_op), .opb_rom_o(opb_rom)
  );

  tea_const_rom #(.DELTA(DELTA), .ROUNDS(ROUNDS)) rom_i (
    .sel(rom_sel), .value(rom_val)
  );

  assign alu_opb = opb_rom ? rom_val : rd_data[1];

  tea_alu #(.SHL(SHL), .SHR(SHR)) alu_i (
    .op(alu_op), .opa(rd_data[0]), .opb(alu_opb),
    .key_lo(rd_data[2]), .key_hi(rd_data[3]), .sum(rd_data[4]),
    .res(alu_res)
  );

  assign wr_data = wr_from_mem ? {WORD_BY{mem_rsp_rdata}} : alu_res;

  tea_regfile #(.NRD(RD_PORTS)) rf_i (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

endmodule

// File: rtl/tea_task_core_chk.sv
module tea_task_core_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              task_start,
  input logic              pwr_en,
  input logic              task_done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [7:0]        mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready
);

  p_wake_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && task_start) |=> pwr_en);

  p_quiet_when_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (!mem_req_valid && !mem_rsp_ready && !task_done));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_wdata)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    task_done |=> !task_done);

  p_gate_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    task_done |=> !pwr_en);

  p_rsp_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);

  p_rsp_needs_power_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready) |=> pwr_en);

endmodule

bind tea_task_core tea_task_core_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .task_start(task_start), .pwr_en(pwr_en),
  .task_done(task_done), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready)
);

// File: tb/tea_task_core_tb_top.sv
`timescale 1ns/1ps
module tea_task_core_tb_top;

  localparam int         ADDR_W = 8;
  localparam logic [7:0] PT_B   = 8'h00;
  localparam logic [7:0] KEY_B  = 8'h10;
  localparam logic [7:0] CT_B   = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic task_start = 1'b0;
  logic pwr_en, task_done;
  logic mem_req_valid, mem_req_write, mem_rsp_ready;
  logic mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [7:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_rdata = 8'h00;

  always #4 clk = ~clk;

  tea_task_core #(.ADDR_W(ADDR_W), .PT_BASE(PT_B), .KEY_BASE(KEY_B), .CT_BASE(CT_B)) dut_i (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .pwr_en(pwr_en),
    .task_done(task_done), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  int checks = 0;
  int errors = 0;

  // shared-RAM model state
  logic [7:0] mem [0:255];
  logic [7:0] rd_log [0:63];
  logic [7:0] wa_log [0:15];
  logic [7:0] wd_log [0:15];
  int  rd_n, wr_n, rsp_n, done_n, stab_err, excl_err, time_err;
  int  cyc = 0, last_wr_cyc = -10, done_cyc = -10;
  bit  stall = 1'b0;
  bit  owed = 1'b0, consumed = 1'b0, was_stalled = 1'b0;
  int  owed_dly = 0;
  logic [7:0] owed_data, held_addr, held_wdata;
  logic held_we;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (was_stalled && !(mem_req_valid && mem_req_addr == held_addr &&
          mem_req_write == held_we && mem_req_wdata == held_wdata)) stab_err++;
      if (mem_rsp_ready && mem_req_valid) excl_err++;
      if (cyc == done_cyc + 1 && pwr_en) time_err++;
      if (task_done) begin
        done_n++;
        done_cyc = cyc;
        if (cyc != last_wr_cyc + 1) time_err++;
      end
      if (consumed) begin mem_rsp_valid = 1'b0; consumed = 1'b0; end
      if (owed) begin
        if (owed_dly > 0) owed_dly--;
        else begin mem_rsp_valid = 1'b1; mem_rsp_rdata = owed_data; end
      end
      if (mem_rsp_valid && mem_rsp_ready) begin consumed = 1'b1; owed = 1'b0; rsp_n++; end
      mem_req_ready = stall ? (cyc % 3 == 0) : 1'b1;
      was_stalled = mem_req_valid && !mem_req_ready;
      held_addr = mem_req_addr; held_we = mem_req_write; held_wdata = mem_req_wdata;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr] = mem_req_wdata;
          if (wr_n < 16) begin wa_log[wr_n] = mem_req_addr; wd_log[wr_n] = mem_req_wdata; end
          wr_n++;
          last_wr_cyc = cyc;
        end else begin
          if (rd_n < 64) rd_log[rd_n] = mem_req_addr;
          rd_n++;
          owed = 1'b1; owed_data = mem[mem_req_addr]; owed_dly = stall ? 2 : 0;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] tea_model(input logic [31:0] y0, z0, a, b, c, d);
    logic [31:0] y, z, s;
    y = y0; z = z0; s = 0;
    for (int i = 0; i < 32; i++) begin
      s = s + 32'h9E3779B9;
      y = y + (((z << 4) + a) ^ (z + s) ^ ((z >> 5) + b));
      z = z + (((y << 4) + c) ^ (y + s) ^ ((y >> 5) + d));
    end
    return {z, y};
  endfunction

  task automatic put_word(input logic [7:0] base, input logic [31:0] w);
    for (int i = 0; i < 4; i++) mem[base + 8'(i)] = w[8*i +: 8];
  endtask

  // R1: outputs at reset
  task automatic test_reset();
    chk("R1", "pwr_en after reset", {63'd0, pwr_en}, 64'd0);
    chk("R1", "done after reset", {63'd0, task_done}, 64'd0);
    chk("R1", "req_valid after reset", {63'd0, mem_req_valid}, 64'd0);
    chk("R1", "rsp_ready after reset", {63'd0, mem_rsp_ready}, 64'd0);
  endtask

  // one job: R3 R4 R5 R6 R7 R8 (and R2/R9 when asked)
  task automatic test_job(input string tag, input logic [31:0] y, z, a, b, c, d,
                          input bit stl, input bit poke);
    logic [63:0] exp, got;
    int waited;
    bit rd_ok = 1'b1, wr_ok = 1'b1;
    stall = stl;
    put_word(PT_B, y); put_word(PT_B + 8'd4, z);
    put_word(KEY_B, a); put_word(KEY_B + 8'd4, b);
    put_word(KEY_B + 8'd8, c); put_word(KEY_B + 8'd12, d);
    for (int i = 0; i < 8; i++) mem[CT_B + 8'(i)] = 8'h00;
    rd_n = 0; wr_n = 0; rsp_n = 0; done_n = 0; stab_err = 0; excl_err = 0; time_err = 0;
    @(negedge clk); #1 task_start = 1'b1;
    @(negedge clk); #1 task_start = 1'b0;
    chk("R2", {tag, " pwr_en after start"}, {63'd0, pwr_en}, 64'd1);
    waited = 0;
    while (done_n == 0 && waited < 5000) begin
      @(negedge clk); #1;
      waited++;
      if (poke && waited == 60) task_start = 1'b1;
      if (poke && waited == 61) task_start = 1'b0;
    end
    if (poke) begin task_start = 1'b1; @(negedge clk); #1 task_start = 1'b0; end
    repeat (12) @(negedge clk);
    #1;
    exp = tea_model(y, z, a, b, c, d);
    got = {mem[CT_B+7], mem[CT_B+6], mem[CT_B+5], mem[CT_B+4],
           mem[CT_B+3], mem[CT_B+2], mem[CT_B+1], mem[CT_B+0]};
    chk("R4", {tag, " cipher y"}, {32'd0, got[31:0]}, {32'd0, exp[31:0]});
    chk("R4", {tag, " cipher z"}, {32'd0, got[63:32]}, {32'd0, exp[63:32]});
    chk("R3", {tag, " read count"}, 64'(rd_n), 64'd24);
    for (int i = 0; i < 24 && i < rd_n; i++)
      if (rd_log[i] != ((i < 8) ? PT_B + 8'(i) : KEY_B + 8'(i - 8))) rd_ok = 1'b0;
    chk("R3", {tag, " read order"}, {63'd0, rd_ok}, 64'd1);
    chk("R5", {tag, " write count"}, 64'(wr_n), 64'd8);
    for (int i = 0; i < 8 && i < wr_n; i++)
      if (wa_log[i] != CT_B + 8'(i) || wd_log[i] != exp[8*i +: 8]) wr_ok = 1'b0;
    chk("R5", {tag, " write order"}, {63'd0, wr_ok}, 64'd1);
    chk("R6", {tag, " stalled request stable"}, 64'(stab_err), 64'd0);
    chk("R7", {tag, " done pulses"}, 64'(done_n), 64'd1);
    chk("R7", {tag, " done/gate timing"}, 64'(time_err), 64'd0);
    chk("R7", {tag, " pwr_en low after job"}, {63'd0, pwr_en}, 64'd0);
    chk("R8", {tag, " responses consumed"}, 64'(rsp_n), 64'd24);
    chk("R8", {tag, " rsp_ready with req_valid"}, 64'(excl_err), 64'd0);
  endtask

  task automatic test_busy_start();
    // R2: start pulses while busy and in the done cycle are ignored
    test_job("busy", 32'h0123_4567, 32'h89AB_CDEF, 32'h0011_2233,
             32'h4455_6677, 32'h8899_AABB, 32'hCCDD_EEFF, 1'b0, 1'b1);
    chk("R2", "busy start: no extra traffic", 64'(rd_n + wr_n), 64'd32);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_job("zero", 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
    test_job("R9 vecA", 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h1234_5678,
             32'h9ABC_DEF0, 32'h0F1E_2D3C, 32'h4B5A_6978, 1'b0, 1'b0);
    test_job("R6 stall", 32'hFFFF_FFFF, 32'h8000_0001, 32'hFFFF_FFFF,
             32'h0000_0001, 32'h7FFF_FFFF, 32'hA5A5_5A5A, 1'b1, 1'b0);
    test_busy_start();
    test_job("R9 repeatA", 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h1234_5678,
             32'h9ABC_DEF0, 32'h0F1E_2D3C, 32'h4B5A_6978, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule